// File: doc/BRIEF.md
# Bidirectional Port with Direction-Dependent Readback

This block is one eight-line general-purpose I/O port on a small CPU bus. It holds two registers at separate bus addresses: a data latch and a direction register. A direction bit of 1 makes its line an input with the output driver off. A direction bit of 0 turns the driver on, and the pad then takes the latch value. A read of the data address returns a per-bit mix. Input lines give the synchronized pad level and output lines give the latch, so a read-modify-write never copies a floating or externally loaded pad back into an output latch.

Both registers accept a full-byte write, a single-bit set or a single-bit clear. One line, pin 3 by default, can carry a divider clock instead of its latch value when the divider option is on. The latch bit of that line then acts as a gate for the divider clock. While the sleep input is high, the block compares the synchronized input lines against a snapshot taken when sleep began. Any difference on an input-configured line raises a wake-up request.

Top module: `gpio_port`

## Requirements
- R1: For each line, `pad_oe` is the inverse of the direction bit: direction 1 means input (driver off), direction 0 means output (driver on).
- R2: A read with `bus_addr`=0 returns, per bit, the synchronized pad level where the direction bit is 1 and the latch bit where it is 0. A read with `bus_addr`=1 returns the direction register.
- R3: The data latch and `pad_out` (divider off) keep their value until a write to `bus_addr`=0 changes them.
- R4: `bus_op` 2'b00 writes the whole byte, 2'b01 sets bit `bus_bit`, 2'b10 clears bit `bus_bit`. These operations apply to whichever register `bus_addr` selects, and they take effect at the rising edge where `bus_wr` is high.
- R5: After reset the latch and the direction register are 8'hFF, `pad_oe` is 0 and `wake_req` is 0.
- R6: Pad inputs pass through two flops. A pad change shows in the readback after the second rising edge and not after the first.
- R7: With `div_en` high, `pad_out[3]` equals `div_sig` while latch bit 3 is 1 and is 0 while latch bit 3 is 0. With `div_en` low, `pad_out[3]` is latch bit 3. The direction bit still controls `pad_oe[3]`.
- R8: While `sleep` stays high, `wake_req` is 1 exactly when some input-configured line's synchronized level differs from its value captured at the first rising edge with `sleep` high. A change on an output-configured line does not wake. `wake_req` is 0 when not sleeping.
- R9: `bus_op` 2'b11 is reserved, and a write with it leaves the selected register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 1 | 0 selects the data latch, 1 the direction register |
| bus_op | input | 2 | Write operation: byte, set bit, clear bit, reserved |
| bus_bit | input | 3 | Bit index for set and clear |
| bus_wdata | input | 8 | Write data for byte writes |
| bus_rdata | output | 8 | Read data for the selected address |
| pad_in | input | 8 | Pad levels |
| pad_out | output | 8 | Pad drive values |
| pad_oe | output | 8 | Pad driver enables, 1 = driving |
| div_en | input | 1 | Replaces pin 3's output with the gated divider clock |
| div_sig | input | 1 | Divider clock |
| sleep | input | 1 | Device sleeping; snapshot taken on entry |
| wake_req | output | 1 | Wake-up request |

## Verification
A bit write to the latch and a readback of the same port can meet in one access pattern. The bench sets a direction so that some lines are inputs driven opposite to their latch bits. It then reads the port, modifies it and writes it back, and checks that `pad_out` holds the output bits and not the pad levels. A pad change during sleep can also arrive while the direction of that line is output. The bench toggles such a line together with an input line in separate phases and judges `wake_req` at the cycle after the second synchronizer edge.

// File: rtl/gpio_port.sv
module gpio_port #(
  parameter int W = 8,
  parameter int DIV_PIN = 3,
  parameter logic [W-1:0] WAKE_MASK = '1,
  localparam int BW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_addr,
  input  logic [1:0]    bus_op,
  input  logic [BW-1:0] bus_bit,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  input  logic [W-1:0]  pad_in,
  output logic [W-1:0]  pad_out,
  output logic [W-1:0]  pad_oe,
  input  logic          div_en,
  input  logic          div_sig,
  input  logic          sleep,
  output logic          wake_req
);

  logic [W-1:0] latch, dir, sync1, sync2, snap;
  logic         sleep_q;
  logic [W-1:0] bit_mask;

  assign bit_mask = {{(W-1){1'b0}}, 1'b1} << bus_bit;

  function automatic logic [W-1:0] apply_op(input logic [W-1:0] cur);
    case (bus_op)
      2'b00:   return bus_wdata;
      2'b01:   return cur | bit_mask;
      2'b10:   return cur & ~bit_mask;
      default: return cur;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch <= '1;
      dir   <= '1;
    end else if (bus_wr) begin
      if (bus_addr) dir   <= apply_op(dir);
      else          latch <= apply_op(latch);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '1;
      sync2 <= '1;
    end else begin
      sync1 <= pad_in;
      sync2 <= sync1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sleep_q <= 1'b0;
      snap    <= '1;
    end else begin
      sleep_q <= sleep;
      if (sleep && !sleep_q) snap <= sync2;
    end
  end

  assign wake_req  = sleep_q && sleep && |((sync2 ^ snap) & dir & WAKE_MASK);
  assign bus_rdata = bus_addr ? dir : ((dir & sync2) | (~dir & latch));
  assign pad_oe    = ~dir;

  for (genvar i = 0; i < W; i++) begin : g_out
    if (i == DIV_PIN) begin : g_div
      assign pad_out[i] = div_en ? (latch[i] & div_sig) : latch[i];
    end else begin : g_plain
      assign pad_out[i] = latch[i];
    end
  end

endmodule

module gpio_port_chk #(
  parameter int W = 8,
  parameter int DIV_PIN = 3,
  localparam int BW = $clog2(W)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_wr,
  input logic          bus_addr,
  input logic [1:0]    bus_op,
  input logic [BW-1:0] bus_bit,
  input logic [W-1:0]  bus_wdata,
  input logic [W-1:0]  latch,
  input logic [W-1:0]  dir,
  input logic [W-1:0]  pad_out,
  input logic [W-1:0]  pad_oe,
  input logic          div_en,
  input logic          sleep_q,
  input logic          wake_req
);

  a_r1_dir_byte_to_oe: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr && bus_op == 2'b00) |=> (pad_oe == ~$past(bus_wdata)));

  a_r3_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && !bus_addr) |=> $stable(latch));

  a_r4_set_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_addr && bus_op == 2'b01) |=> latch[$past(bus_bit)]);

  a_r4_clear_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_addr && bus_op == 2'b10) |=> !latch[$past(bus_bit)]);

  a_r7_div_gated_low: assert property (@(posedge clk) disable iff (!rst_n)
    (div_en && !latch[DIV_PIN]) |-> !pad_out[DIV_PIN]);

  a_r8_no_wake_awake: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep_q |-> !wake_req);

  a_r9_reserved_op: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_op == 2'b11) |=> ($stable(latch) && $stable(dir)));

endmodule

bind gpio_port gpio_port_chk #(.W(W), .DIV_PIN(DIV_PIN)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_op(bus_op), .bus_bit(bus_bit), .bus_wdata(bus_wdata),
  .latch(latch), .dir(dir), .pad_out(pad_out), .pad_oe(pad_oe),
  .div_en(div_en), .sleep_q(sleep_q), .wake_req(wake_req)
);

// File: tb/test_gpio_port.sv
module test_gpio_port;
  logic       clk = 0, rst_n = 0;
  logic       bus_wr = 0, bus_addr = 0;
  logic [1:0] bus_op = 0;
  logic [2:0] bus_bit = 0;
  logic [7:0] bus_wdata = 0, bus_rdata, pad_in = 0, pad_out, pad_oe;
  logic       div_en = 0, div_sig = 0, sleep = 0, wake_req;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  gpio_port i_gpio_port (.*);

  // {dir, latch, pad, expected readback}
  localparam logic [31:0] VEC [6] = '{
    32'hFF_00_A5_A5, 32'h00_3C_FF_3C, 32'hF0_5A_0F_0A,
    32'h0F_C3_96_C6, 32'hAA_55_FF_FF, 32'h55_00_00_00};

  task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [1:0] op, input logic [2:0] b, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_op = op; bus_bit = b; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0; bus_addr = 0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    bus_addr = a; #1; d = bus_rdata; bus_addr = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R5 reset state
    rd(1, r); check(r == 8'hFF, "R5 dir reset", r, 8'hFF);
    check(pad_oe == 8'h00, "R5 oe reset", pad_oe, 8'h00);
    check(wake_req == 0, "R5 wake reset", {7'b0, wake_req}, 8'h00);
    wr(1, 2'b00, 0, 8'h00);
    check(pad_out == 8'hFF, "R5 latch reset ones", pad_out, 8'hFF);

    // table walk: R1 R2
    foreach (VEC[k]) begin
      wr(1, 2'b00, 0, VEC[k][31:24]);
      wr(0, 2'b00, 0, VEC[k][23:16]);
      pad_in = VEC[k][15:8];
      repeat (3) @(negedge clk);
      rd(0, r); check(r == VEC[k][7:0], "R2 readback mix", r, VEC[k][7:0]);
      check(pad_oe == ~VEC[k][31:24], "R1 oe from dir", pad_oe, ~VEC[k][31:24]);
      rd(1, r); check(r == VEC[k][31:24], "R2 dir readback", r, VEC[k][31:24]);
    end

    // R6 two-flop latency
    wr(1, 2'b00, 0, 8'hFF);
    pad_in = 8'h00; repeat (3) @(negedge clk);
    pad_in = 8'h81;
    @(negedge clk); rd(0, r); check(r == 8'h00, "R6 not after first edge", r, 8'h00);
    @(negedge clk); rd(0, r); check(r == 8'h81, "R6 after second edge", r, 8'h81);

    // R4 set/clear, R9 reserved, R3 hold
    wr(1, 2'b00, 0, 8'h00);
    wr(0, 2'b00, 0, 8'h00);
    wr(0, 2'b01, 5, 8'h00); check(pad_out == 8'h20, "R4 set bit 5", pad_out, 8'h20);
    wr(0, 2'b01, 7, 8'h00); check(pad_out == 8'hA0, "R4 set bit 7", pad_out, 8'hA0);
    wr(0, 2'b10, 5, 8'hFF); check(pad_out == 8'h80, "R4 clear bit 5", pad_out, 8'h80);
    wr(0, 2'b11, 0, 8'hFF); check(pad_out == 8'h80, "R9 reserved on latch", pad_out, 8'h80);
    wr(1, 2'b11, 0, 8'hFF); check(pad_oe == 8'hFF, "R9 reserved on dir", pad_oe, 8'hFF);
    wr(1, 2'b01, 2, 8'h00); check(pad_oe == 8'hFB, "R4 set dir bit 2", pad_oe, 8'hFB);
    wr(1, 2'b10, 2, 8'h00); check(pad_oe == 8'hFF, "R4 clear dir bit 2", pad_oe, 8'hFF);
    pad_in = 8'h5A; repeat (5) @(negedge clk);
    check(pad_out == 8'h80, "R3 latch holds", pad_out, 8'h80);

    // R2 read-modify-write with mixed directions
    wr(1, 2'b00, 0, 8'h0F);
    wr(0, 2'b00, 0, 8'h30);
    pad_in = 8'hFF; repeat (3) @(negedge clk);
    rd(0, r); check(r == 8'h3F, "R2 rmw read", r, 8'h3F);
    wr(0, 2'b00, 0, r | 8'h40);
    check(pad_out == 8'h7F, "R2 rmw writeback", pad_out, 8'h7F);

    // R7 divider on pin 3
    wr(1, 2'b00, 0, 8'h00);
    wr(0, 2'b00, 0, 8'h08);
    div_en = 1; div_sig = 1; #1;
    check(pad_out[3] == 1, "R7 div high", {7'b0, pad_out[3]}, 8'h01);
    div_sig = 0; #1;
    check(pad_out[3] == 0, "R7 div low", {7'b0, pad_out[3]}, 8'h00);
    wr(0, 2'b10, 3, 8'h00);
    div_sig = 1; #1;
    check(pad_out[3] == 0, "R7 gated by latch", {7'b0, pad_out[3]}, 8'h00);
    div_en = 0; wr(0, 2'b01, 3, 8'h00); div_sig = 0; #1;
    check(pad_out[3] == 1, "R7 div off uses latch", {7'b0, pad_out[3]}, 8'h01);
    wr(1, 2'b01, 3, 8'h00);
    check(pad_oe[3] == 0, "R7 dir controls oe", {7'b0, pad_oe[3]}, 8'h00);

    // R8 wake
    wr(1, 2'b00, 0, 8'hF0);
    pad_in = 8'h00; repeat (3) @(negedge clk);
    pad_in = 8'h10; repeat (3) @(negedge clk);
    check(wake_req == 0, "R8 no wake when awake", {7'b0, wake_req}, 8'h00);
    sleep = 1; repeat (2) @(negedge clk);
    check(wake_req == 0, "R8 no change no wake", {7'b0, wake_req}, 8'h00);
    pad_in = 8'h13; repeat (3) @(negedge clk);
    check(wake_req == 0, "R8 output line no wake", {7'b0, wake_req}, 8'h00);
    pad_in = 8'h03;
    @(negedge clk); check(wake_req == 0, "R8 wake after two edges only", {7'b0, wake_req}, 8'h00);
    @(negedge clk); check(wake_req == 1, "R8 input change wakes", {7'b0, wake_req}, 8'h01);
    sleep = 0; #1;
    check(wake_req == 0, "R8 cleared on exit", {7'b0, wake_req}, 8'h00);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule